// File: doc/BRIEF.md
# Time-Slot Interchanger with Per-Channel Delay Mode

This block moves byte-wide channels from an incoming time-division frame into an outgoing one. Each incoming byte is stored under its channel number in a data store that has two banks. A connection table holds one entry per outgoing channel: the number of the incoming channel to copy, and a delay-mode bit. When the output side asks for a channel, the block looks up its entry, picks a bank and returns the stored byte one cycle later.

The mode bit trades latency against frame integrity. In low-latency mode a byte comes from the frame still being received, provided its source slot lies far enough behind the requested slot; otherwise the copy from the previous frame is used. The threshold, called LAG, is `NCH/16 + 1` slots (3 at 32 channels, 5 at 64, 9 at 128). In frame-aligned mode every outgoing channel of frame k comes from incoming frame k-1, so channels sent together on the way in stay together on the way out. A control port writes a shadow copy of the table, and the whole shadow becomes active at the next frame marker.

The input stream has valid/ready. Ready is always high, so the input never stalls. The fetch side has no back-pressure: every fetch is answered exactly one cycle later, and the response cannot be held off. The frame marker, the control port and the reset are plain level inputs.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `out_valid` is low, both data banks read as zero, and every table entry selects source channel 0 in frame-aligned mode (mode bit 1).
- R2: `out_valid` is high in the cycle after a cycle with `fetch_valid` high, and low in the cycle after a cycle with `fetch_valid` low. `out_data` is sampled with `out_valid`.
- R3: A high `frame_sync` marks slot 0 of a new frame. The input write, the fetch and the table swap in that same cycle all belong to the new frame. Successive frames are stored in alternate banks.
- R4: With mode bit 1, output channel m with source n in frame k returns the byte that channel n carried in frame k-1, whatever m and n are.
- R5: With mode bit 0 and m >= n + LAG, the byte that channel n carried earlier in the same frame is returned.
- R6: With mode bit 0 and m < n, the byte from the previous frame is returned.
- R7: With mode bit 0 and n <= m < n + LAG, the byte from the previous frame is returned. At m = n + LAG the same-frame byte is returned instead.
- R8: A table write (`cfg_we` high) changes nothing that is fetched in the current frame. It takes effect from the next `frame_sync`. A write in the same cycle as `frame_sync` applies from the frame after.
- R9: `in_ready` is always high. A cycle with `in_valid` low leaves the bank unchanged, so that slot later reads the bank's older content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in slot 0 of each frame |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Always high; the input is never stalled |
| in_chan | input | $clog2(NCH) | Incoming channel number |
| in_data | input | DW | Incoming byte |
| fetch_valid | input | 1 | Request for an outgoing channel |
| fetch_chan | input | $clog2(NCH) | Outgoing channel number requested |
| out_valid | output | 1 | Response present, one cycle after the fetch |
| out_data | output | DW | Switched byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_chan | input | $clog2(NCH) | Outgoing channel whose entry is written |
| cfg_src | input | $clog2(NCH) | Source channel for that entry |
| cfg_mode | input | 1 | 0 = low latency, 1 = frame aligned |

## Verification
Each frame writes a distinct byte per channel, so a response identifies which frame it came from and which channel it came from. The tests use five connection patterns:
- the reset table;
- reversed channels in frame-aligned mode;
- identity mapping in low-latency mode;
- offsets of 0 to 4 slots plus one slot ahead, which fall on both sides of LAG and across the frame wrap;
- a mix of modes over a scattered mapping.

Together these separate same-frame reads from previous-frame reads at the LAG boundary. A table write in the middle of a frame, and a frame that skips its odd inputs, show whether updates are deferred to the next frame and whether idle input slots write anything.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam logic MODE_VAR   = 1'b0;
  localparam logic MODE_CONST = 1'b1;

  // Slots a source must lead its destination by for a same-frame read
  function automatic int lag_slots(input int nch);
    return nch / 16 + 1;
  endfunction
endpackage

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NCH = 32,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_chan,
  input  logic [CW-1:0] cfg_src,
  input  logic          cfg_mode,
  input  logic [CW-1:0] rd_chan,
  output logic [CW-1:0] rd_src,
  output logic          rd_mode
);
  import tsi_pkg::*;

  logic [NCH-1:0][CW-1:0] sh_src, act_src;
  logic [NCH-1:0]         sh_mode, act_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_src   <= '0;
      act_src  <= '0;
      sh_mode  <= {NCH{MODE_CONST}};
      act_mode <= {NCH{MODE_CONST}};
    end else begin
      if (cfg_we) begin
        sh_src[cfg_chan]  <= cfg_src;
        sh_mode[cfg_chan] <= cfg_mode;
      end
      if (frame_sync) begin
        act_src  <= sh_src;
        act_mode <= sh_mode;
      end
    end
  end

  // The fetch in the marker cycle already belongs to the new frame
  always_comb begin
    if (frame_sync) begin
      rd_src  = sh_src[rd_chan];
      rd_mode = sh_mode[rd_chan];
    end else begin
      rd_src  = act_src[rd_chan];
      rd_mode = act_mode[rd_chan];
    end
  end

  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> ($stable(act_src) && $stable(act_mode)));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NCH = 32,
  parameter int DW  = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wbank,
  input  logic [CW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          rbank,
  input  logic [CW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [1:0][NCH-1:0][DW-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      rdata  <= '0;
    end else begin
      if (we) bank_q[wbank][waddr] <= wdata;
      if (re) rdata <= bank_q[rbank][raddr];
    end
  end

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/tsi_rd_sel.sv
module tsi_rd_sel #(
  parameter int NCH = 32,
  parameter int CW  = $clog2(NCH),
  parameter int LAG = tsi_pkg::lag_slots(NCH)
) (
  input  logic [CW-1:0] dst_chan,
  input  logic [CW-1:0] src_chan,
  input  logic          mode,
  output logic          use_cur
);
  import tsi_pkg::*;

  localparam logic [CW-1:0] LAG_V = CW'(LAG);

  logic [CW-1:0] gap;
  logic          ahead;

  always_comb begin
    gap     = dst_chan - src_chan;
    ahead   = (dst_chan >= src_chan);
    use_cur = (mode == MODE_VAR) && ahead && (gap >= LAG_V);
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_chan,
  input  logic [DW-1:0] in_data,
  input  logic          fetch_valid,
  input  logic [CW-1:0] fetch_chan,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_chan,
  input  logic [CW-1:0] cfg_src,
  input  logic          cfg_mode
);
  localparam int LAG = tsi_pkg::lag_slots(NCH);

  logic          wr_bank;
  logic          cur_bank;
  logic [CW-1:0] src_n;
  logic          mode_n;
  logic          use_cur;
  logic          rd_bank;

  assign in_ready = 1'b1;
  assign cur_bank = wr_bank ^ frame_sync;
  assign rd_bank  = use_cur ? cur_bank : ~cur_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (frame_sync) wr_bank <= ~wr_bank;
      out_valid <= fetch_valid;
    end
  end

  tsi_conn_mem #(.NCH(NCH), .CW(CW)) u_cm (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_src(cfg_src), .cfg_mode(cfg_mode),
    .rd_chan(fetch_chan), .rd_src(src_n), .rd_mode(mode_n)
  );

  tsi_rd_sel #(.NCH(NCH), .CW(CW), .LAG(LAG)) u_sel (
    .dst_chan(fetch_chan), .src_chan(src_n), .mode(mode_n), .use_cur(use_cur)
  );

  tsi_data_mem #(.NCH(NCH), .DW(DW), .CW(CW)) u_dm (
    .clk(clk), .rst_n(rst_n),
    .we(in_valid), .wbank(cur_bank), .waddr(in_chan), .wdata(in_data),
    .re(fetch_valid), .rbank(rd_bank), .raddr(src_n), .rdata(out_data)
  );

  p_resp_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> out_valid);
  p_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !out_valid);
  p_bank_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (wr_bank != $past(wr_bank)));
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(wr_bank));
endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int NCH = 32;
  localparam int DW  = 8;
  localparam int CW  = $clog2(NCH);
  localparam int LAG = NCH / 16 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CW-1:0] in_chan = '0;
  logic [DW-1:0] in_data = '0;
  logic fetch_valid = 1'b0;
  logic [CW-1:0] fetch_chan = '0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_chan = '0;
  logic [CW-1:0] cfg_src = '0;
  logic cfg_mode = 1'b0;

  always #2 clk = ~clk;

  tsi_switch #(.NCH(NCH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
    .fetch_valid(fetch_valid), .fetch_chan(fetch_chan),
    .out_valid(out_valid), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_src(cfg_src), .cfg_mode(cfg_mode)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int frame_no = 0;
  bit prev_skip = 0;
  bit prev_mid  = 0;
  bit done = 0;

  int mbank [2][NCH];
  int sh_src [NCH];
  int sh_mode[NCH];
  int ac_src [NCH];
  int ac_mode[NCH];

  function automatic int dval(input int f, input int n);
    return (f * 29 + n * 7 + 3) % 256;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < NCH; i++) begin
      mbank[0][i] = 0; mbank[1][i] = 0;
      sh_src[i] = 0; sh_mode[i] = 1; ac_src[i] = 0; ac_mode[i] = 1;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", out_valid, 0, "out_valid after reset");
    chk("R9", in_ready, 1, "in_ready after reset");
  endtask

  // Load the whole shadow table; pattern picks the mapping
  task automatic t_load(input int pat);
    for (int m = 0; m < NCH; m++) begin
      int s, md, d;
      case (pat)
        0: begin s = NCH - 1 - m; md = 1; end
        1: begin s = m; md = 0; end
        2: begin
          d = m % 6;
          s = (d == 5) ? (m + 1) % NCH : (m - d + NCH) % NCH;
          md = 0;
        end
        default: begin s = (m * 7) % NCH; md = m % 2; end
      endcase
      @(negedge clk);
      cfg_we = 1'b1; cfg_chan = CW'(m); cfg_src = CW'(s); cfg_mode = md[0];
      sh_src[m] = s; sh_mode[m] = md;
      @(posedge clk);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_frame(input bit skip_odd, input bit mid_cfg);
    int cur;
    frame_no++;
    cur = frame_no % 2;
    for (int i = 0; i < NCH; i++) begin ac_src[i] = sh_src[i]; ac_mode[i] = sh_mode[i]; end
    for (int s = 0; s < NCH; s++) begin
      int n, exp;
      bit usecur;
      string tag;
      @(negedge clk);
      frame_sync  = (s == 0);
      in_valid    = !(skip_odd && (s % 2 == 1));
      in_chan     = CW'(s);
      in_data     = DW'(dval(frame_no, s));
      fetch_valid = 1'b1;
      fetch_chan  = CW'(s);
      cfg_we      = 1'b0;
      if (mid_cfg && s == 10) begin
        cfg_we = 1'b1; cfg_chan = CW'(20); cfg_src = '0; cfg_mode = 1'b0;
        sh_src[20] = 0; sh_mode[20] = 0;
      end
      n = ac_src[s];
      usecur = (ac_mode[s] == 0) && (s >= n) && (s - n >= LAG);
      exp = usecur ? mbank[cur][n] : mbank[1 - cur][n];
      if (in_valid) mbank[cur][s] = dval(frame_no, s);
      if (frame_no == 1) tag = "R1";
      else if (mid_cfg && s == 20) tag = "R8";
      else if (prev_mid && s == 20) tag = "R8";
      else if (prev_skip && (n % 2 == 1) && !usecur) tag = "R9";
      else if (s == 0) tag = "R3";
      else if (ac_mode[s] == 1) tag = "R4";
      else if (usecur) tag = "R5";
      else if (s < n) tag = "R6";
      else tag = "R7";
      @(posedge clk); #1;
      chk("R2", out_valid, 1, "out_valid after fetch");
      chk(tag, out_data, exp, $sformatf("frame %0d out chan %0d src %0d", frame_no, s, n));
    end
    @(negedge clk);
    frame_sync = 1'b0; in_valid = 1'b0; fetch_valid = 1'b0; cfg_we = 1'b0;
    @(posedge clk); #1;
    chk("R2", out_valid, 0, "out_valid after idle cycle");
    prev_skip = skip_odd;
    prev_mid  = mid_cfg;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame(0, 0);   // R1: reset table, zeroed banks
    t_load(0);       // R4: reversed, frame aligned
    t_frame(0, 0);
    t_frame(0, 0);
    t_load(1);       // R7: identity, low latency
    t_frame(0, 0);
    t_load(2);       // R5/R6/R7 boundaries around LAG
    t_frame(0, 0);
    t_frame(0, 0);
    t_load(3);       // mixed modes
    t_frame(0, 0);
    t_frame(0, 1);   // R8: mid-frame table write deferred
    t_frame(0, 0);
    t_frame(1, 0);   // R9: odd inputs idle
    t_frame(0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule